// File: doc/BRIEF.md
# CVSD Speech Decoder Integrator

This block rebuilds a speech estimate from a continuously variable slope delta code. It takes one code bit per sample period, about 32 kHz, and keeps a 16-bit signed staircase estimate. Each bit moves the estimate up or down by an adaptive step. The step grows when the three most recent bits agree and decays geometrically otherwise. This makes the staircase follow steep slopes while staying fine on quiet passages.

The step adaptation and the saturating integrator use the same arithmetic as the matching encoder's predictor. The reconstructed sample therefore equals the encoder's prediction on every sample. The staircase still carries high-frequency content, so a smoothing low-pass filter downstream takes each sample as it is marked valid.

The decay factor is 219/256, about 0.855. The step floor and the reset step are both 1409, which is 0.043 of full scale. The default build uses these values.

Top module: `cvsd_dec_integrator`

## Requirements
- R1: After reset, `sample` is 0 and `sample_vld` is 0. The first accepted bit moves `sample` by exactly 1409.
- R2: `sample_vld` is 1 in the cycle after each cycle with `bit_vld` high, and 0 otherwise.
- R3: An accepted bit of 1 adds the new step to `sample`. An accepted bit of 0 subtracts it. The new step is computed including that bit.
- R4: When the accepted bit equals the two bits accepted before it, the new step is floor(old step × 219 / 256) + 1409, limited by R6.
- R5: Without such a run of three, the new step is floor(old step × 219 / 256), never below 1409.
- R6: The step never exceeds 8192.
- R7: `sample` saturates at +32767 and −32768 and never wraps.
- R8: While `bit_vld` is low, `sample` holds its value.
- R9: A run of three needs three accepted bits since reset. The first two bits after reset never count as a run.
- R10: When the code comes from an encoder that uses the same predictor, `sample` equals that encoder's prediction after every bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Code bit present this cycle |
| code_bit | input | 1 | Received code bit, 1 = up, 0 = down |
| sample | output | 16 | Reconstructed signed sample |
| sample_vld | output | 1 | Sample updated in the previous edge |

## Verification
The assertions check on every cycle:
- the valid strobe timing;
- the hold while idle;
- the direction of each move;
- the bounds on the internal step.

The exact step values, with the decay floor, the run rule and its start-up exclusion, are visible only in the bench scenarios. The same holds for the saturation points and lockstep with an encoder on a triangle input. The bench sweeps every 8-bit pattern from reset and compares each output against an arithmetic model.

// File: rtl/cvsd_dec_integrator.sv
module cvsd_dec_integrator #(
  parameter int W          = 16,
  parameter int STEP_W     = 16,
  parameter int BETA_NUM   = 219,
  parameter int BETA_SHIFT = 8,
  parameter int STEP_MIN   = 1409,
  parameter int STEP_INC   = 1409,
  parameter int STEP_MAX   = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_vld,
  input  logic                code_bit,
  output logic signed [W-1:0] sample,
  output logic                sample_vld
);
  localparam int PROD_W = STEP_W + BETA_SHIFT;
  localparam int RAW_W  = STEP_W + 1;
  localparam int SUM_W  = W + 2;
  localparam logic signed [SUM_W-1:0] POS_LIM = SUM_W'((2 ** (W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] NEG_LIM = -SUM_W'(2 ** (W - 1));

  logic [STEP_W-1:0] step_q, step_d;
  logic [1:0]        hist;
  logic [1:0]        fill;
  logic              run;
  logic [PROD_W-1:0] prod;
  logic [RAW_W-1:0]  raw;
  logic signed [SUM_W-1:0] sum;
  logic signed [W-1:0]     sat;

  assign run  = (fill == 2'd2) && (hist[0] == code_bit) && (hist[1] == code_bit);
  assign prod = PROD_W'(step_q) * PROD_W'(BETA_NUM);
  assign raw  = RAW_W'(prod >> BETA_SHIFT) + (run ? RAW_W'(STEP_INC) : RAW_W'(0));

  always_comb begin
    if (raw > RAW_W'(STEP_MAX))      step_d = STEP_W'(STEP_MAX);
    else if (raw < RAW_W'(STEP_MIN)) step_d = STEP_W'(STEP_MIN);
    else                             step_d = STEP_W'(raw);
  end

  assign sum = code_bit ? SUM_W'(sample) + $signed({2'b00, step_d})
                        : SUM_W'(sample) - $signed({2'b00, step_d});

  always_comb begin
    if (sum > POS_LIM)      sat = W'(POS_LIM);
    else if (sum < NEG_LIM) sat = W'(NEG_LIM);
    else                    sat = W'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q     <= STEP_W'(STEP_MIN);
      hist       <= 2'b00;
      fill       <= 2'd0;
      sample     <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample_vld <= bit_vld;
      if (bit_vld) begin
        step_q <= step_d;
        hist   <= {hist[0], code_bit};
        fill   <= (fill == 2'd2) ? 2'd2 : fill + 2'd1;
        sample <= sat;
      end
    end
  end
endmodule

// File: rtl/cvsd_dec_integrator_chk.sv
module cvsd_dec_integrator_chk #(
  parameter int W        = 16,
  parameter int STEP_W   = 16,
  parameter int STEP_MIN = 1409,
  parameter int STEP_MAX = 8192
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bit_vld,
  input logic                code_bit,
  input logic signed [W-1:0] sample,
  input logic                sample_vld,
  input logic [STEP_W-1:0]   step_q
);
  p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> sample_vld);
  p_vld_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> !sample_vld);
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(sample));
  p_up_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && code_bit) |=> (sample >= $past(sample)));
  p_down_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !code_bit) |=> (sample <= $past(sample)));
  p_step_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= STEP_W'(STEP_MAX));
  p_step_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_q >= STEP_W'(STEP_MIN));
endmodule

bind cvsd_dec_integrator cvsd_dec_integrator_chk #(
  .W(W), .STEP_W(STEP_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .code_bit(code_bit),
  .sample(sample), .sample_vld(sample_vld), .step_q(step_q)
);

// File: tb/cvsd_dec_integrator_tb.sv
module cvsd_dec_integrator_tb;
  logic clk = 0, rst_n = 0, bit_vld = 0, code_bit = 0;
  logic signed [15:0] sample;
  logic sample_vld;
  int n_chk = 0, n_fail = 0;
  int m_step, m_acc, m_h0, m_h1, m_fill;

  always #5 clk = ~clk;

  cvsd_dec_integrator u_dut (.clk(clk), .rst_n(rst_n), .bit_vld(bit_vld),
    .code_bit(code_bit), .sample(sample), .sample_vld(sample_vld));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_step = 1409; m_acc = 0; m_h0 = 0; m_h1 = 0; m_fill = 0;
  endtask

  task automatic model_bit(int b);
    int run, s;
    run = (m_fill == 2 && m_h0 == b && m_h1 == b) ? 1 : 0;
    s = ((m_step * 219) >>> 8) + (run ? 1409 : 0);
    if (s > 8192) s = 8192;
    if (s < 1409) s = 1409;
    m_step = s;
    m_acc = b ? m_acc + s : m_acc - s;
    if (m_acc > 32767) m_acc = 32767;
    if (m_acc < -32768) m_acc = -32768;
    m_h1 = m_h0; m_h0 = b;
    if (m_fill < 2) m_fill++;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; bit_vld = 0;
    @(negedge clk); rst_n = 1;
    model_reset();
  endtask

  task automatic send(int b, string req);
    @(negedge clk); bit_vld = 1; code_bit = b[0];
    @(negedge clk); bit_vld = 0;
    model_bit(b);
    check(req, int'(sample), m_acc);
    check("R2", int'(sample_vld), 1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int hold, x, dir;
    do_reset();
    // R1 reset state
    check("R1", int'(sample), 0);
    check("R1", int'(sample_vld), 0);
    send(1, "R1");
    check("R1", int'(sample), 1409);

    // R9: first two bits never a run; third equal bit is
    do_reset();
    send(0, "R9"); send(0, "R9");
    check("R9", int'(sample), -2818);
    send(0, "R9");
    check("R9", int'(sample), -2818 - 2614);

    // R3/R4/R5 exhaustive sweep of every 8-bit pattern from reset
    for (int p = 0; p < 256; p++) begin
      do_reset();
      for (int k = 0; k < 8; k++) send((p >> k) & 1, "R4_R5_R3");
    end

    // R8: idle cycles hold the sample, strobe low
    hold = int'(sample);
    repeat (5) @(negedge clk);
    check("R8", int'(sample), hold);
    check("R2", int'(sample_vld), 0);

    // R6/R7: long run of ones saturates; one zero then reveals decayed ceiling
    do_reset();
    for (int k = 0; k < 30; k++) send(1, "R7");
    check("R7", int'(sample), 32767);
    send(0, "R6");
    check("R6", int'(sample), 32767 - 7008);
    do_reset();
    for (int k = 0; k < 30; k++) send(0, "R7");
    check("R7", int'(sample), -32768);

    // R10: encoder in lockstep on a triangle input
    do_reset();
    x = 0; dir = 1;
    for (int k = 0; k < 600; k++) begin
      x += dir * 1250;
      if (x >= 20000 || x <= -20000) dir = -dir;
      send((x >= m_acc) ? 1 : 0, "R10");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule